// File: doc/BRIEF.md
# Exact Product Alignment Unit

This block takes two floating-point operands, each given as a sign bit, a biased exponent field and a fraction field. It forms their exact product without rounding or normalization. It then recasts that product into the form a segmented long accumulator consumes. The accumulator is assumed to be built from words of 2^LOG2_WORD bits.

The product exponent is rebased so that the lightest possible product bit lands on accumulator bit 0. Its upper bits name the lowest accumulator word touched. Its low LOG2_WORD bits shift the product mantissa inside a field that spans just enough words. When the product is negative, the field is sent as a two's-complement value, together with a sign flag that tells the accumulator to sign-extend into the higher words. Subnormal operands are handled. Infinity and NaN get no special treatment.

One register stage sits at the output. A pulse on `in_valid` yields a result and `out_valid` one clock later.

Top module: `kpa_product_align`

## Requirements
- R1: `out_sign` is the XOR of the two operand signs, except that it is 0 whenever either operand is zero.
- R2: An operand whose exponent field is 0 has an implicit leading bit of 0 and is treated as having exponent 1. An operand with any other exponent field has an implicit leading bit of 1.
- R3: With effective exponents ea and eb, the rebased product exponent is P = ea + eb − 2. `out_addr` is P >> LOG2_WORD, and the shift is P mod 2^LOG2_WORD.
- R4: For a positive product, `out_field` equals the exact (FRAC_W+1)×(FRAC_W+1)-bit significand product shifted left by the shift of R3. All bits at or above position 2·FRAC_W+1+2^LOG2_WORD are 0.
- R5: For a negative product, `out_field` equals 2^FIELD_W minus the shifted magnitude of R4. Its top bit is then 1, matching `out_sign`.
- R6: If either operand is zero (exponent field 0 and fraction 0), `out_field` is all zeros and `out_sign` is 0.
- R7: `out_valid` is `in_valid` delayed by one clock. While `in_valid` is low, `out_sign`, `out_addr` and `out_field` hold their values.
- R8: While `rst_n` is low, `out_valid`, `out_sign`, `out_addr` and `out_field` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are present this cycle |
| a_sign | input | 1 | Sign of operand A |
| a_exp | input | EXP_W | Biased exponent field of A |
| a_frac | input | FRAC_W | Fraction field of A |
| b_sign | input | 1 | Sign of operand B |
| b_exp | input | EXP_W | Biased exponent field of B |
| b_frac | input | FRAC_W | Fraction field of B |
| out_valid | output | 1 | Result registered from the previous cycle |
| out_sign | output | 1 | Product is negative |
| out_addr | output | EXP_W+1−LOG2_WORD | Index of the lowest accumulator word touched |
| out_field | output | FIELD_W | Shifted two's-complement mantissa spanning the touched words |

## Verification
A wrong subnormal decision or a wrong rebase offset shows up in the very next valid result as an address or shift off by one position, so the field lands one bit or one word away from where it belongs. A sign error appears in the same cycle as a field whose top bit disagrees with `out_sign`, or as a zero product that is marked negative and would sign-extend garbage into the accumulator. Operand sweeps compare each registered result against an independent wide-integer product. Directed cases pin down the extremes of the shift and address range and the hold behaviour between valid pulses.

// File: rtl/kpa_pkg.sv
package kpa_pkg;
   function automatic int unsigned kpa_cdiv(int unsigned num, int unsigned den);
      return (num + den - 1) / den;
   endfunction
endpackage

// File: rtl/kpa_unpack.sv
module kpa_unpack #(
   parameter int EXP_W  = 5,
   parameter int FRAC_W = 10
) (
   input  logic [EXP_W-1:0]  exp_i,
   input  logic [FRAC_W-1:0] frac_i,
   output logic [FRAC_W:0]   sig_o,
   output logic [EXP_W-1:0]  eff_exp_o,
   output logic              zero_o
);
   logic subn;
   always_comb begin
      subn      = (exp_i == '0);
      // subnormal: hidden bit cleared, exponent read as 1
      sig_o     = {~subn, frac_i};
      eff_exp_o = subn ? EXP_W'(1) : exp_i;
      zero_o    = subn && (frac_i == '0);
   end
endmodule

// File: rtl/kpa_mul.sv
module kpa_mul #(
   parameter int EXP_W  = 5,
   parameter int FRAC_W = 10,
   localparam int SIG_W  = FRAC_W + 1,
   localparam int MANT_W = 2 * FRAC_W + 2,
   localparam int PEXP_W = EXP_W + 1
) (
   input  logic              sign_a_i,
   input  logic              sign_b_i,
   input  logic [SIG_W-1:0]  sig_a_i,
   input  logic [SIG_W-1:0]  sig_b_i,
   input  logic [EXP_W-1:0]  eff_a_i,
   input  logic [EXP_W-1:0]  eff_b_i,
   input  logic              zero_a_i,
   input  logic              zero_b_i,
   output logic [MANT_W-1:0] mant_o,
   output logic [PEXP_W-1:0] pexp_o,
   output logic              neg_o
);
   always_comb begin
      mant_o = MANT_W'(sig_a_i) * MANT_W'(sig_b_i);
      // rebase so the smallest product weight maps to accumulator bit 0
      pexp_o = PEXP_W'(eff_a_i) + PEXP_W'(eff_b_i) - PEXP_W'(2);
      neg_o  = (sign_a_i ^ sign_b_i) & ~(zero_a_i | zero_b_i);
   end
endmodule

// File: rtl/kpa_align.sv
module kpa_align #(
   parameter int MANT_W    = 22,
   parameter int PEXP_W    = 6,
   parameter int LOG2_WORD = 4,
   parameter int FIELD_W   = 48,
   parameter bit NEG_INV   = 1'b1,
   localparam int ADDR_W   = PEXP_W - LOG2_WORD
) (
   input  logic [MANT_W-1:0]  mant_i,
   input  logic [PEXP_W-1:0]  pexp_i,
   input  logic               neg_i,
   output logic [ADDR_W-1:0]  addr_o,
   output logic [FIELD_W-1:0] field_o
);
   logic [LOG2_WORD-1:0] shamt;
   logic [FIELD_W-1:0]   stg [LOG2_WORD+1];
   logic [FIELD_W-1:0]   mag;

   assign shamt  = pexp_i[LOG2_WORD-1:0];
   assign addr_o = pexp_i[PEXP_W-1:LOG2_WORD];
   assign stg[0] = FIELD_W'(mant_i);

   for (genvar j = 0; j < LOG2_WORD; j++) begin : g_shift
      assign stg[j+1] = shamt[j] ? (stg[j] << (1 << j)) : stg[j];
   end

   assign mag = stg[LOG2_WORD];

   if (NEG_INV) begin : g_neg_inv
      assign field_o = neg_i ? (~mag + FIELD_W'(1)) : mag;
   end else begin : g_neg_sub
      assign field_o = neg_i ? (FIELD_W'(0) - mag) : mag;
   end
endmodule

// File: rtl/kpa_product_align.sv
module kpa_product_align #(
   parameter int EXP_W     = 5,
   parameter int FRAC_W    = 10,
   parameter int LOG2_WORD = 4,
   parameter bit NEG_INV   = 1'b1,
   localparam int SIG_W    = FRAC_W + 1,
   localparam int MANT_W   = 2 * FRAC_W + 2,
   localparam int PEXP_W   = EXP_W + 1,
   localparam int WORD_W   = 1 << LOG2_WORD,
   localparam int SPAN_W   = MANT_W - 1 + WORD_W,
   localparam int SEG_N    = int'(kpa_pkg::kpa_cdiv(SPAN_W, WORD_W)),
   localparam int FIELD_W  = SEG_N * WORD_W,
   localparam int ADDR_W   = PEXP_W - LOG2_WORD
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic               a_sign,
   input  logic [EXP_W-1:0]   a_exp,
   input  logic [FRAC_W-1:0]  a_frac,
   input  logic               b_sign,
   input  logic [EXP_W-1:0]   b_exp,
   input  logic [FRAC_W-1:0]  b_frac,
   output logic               out_valid,
   output logic               out_sign,
   output logic [ADDR_W-1:0]  out_addr,
   output logic [FIELD_W-1:0] out_field
);
   if (EXP_W < 2) begin : g_bad_exp
      $error("kpa_product_align: EXP_W must be at least 2");
   end
   if (FRAC_W < 1) begin : g_bad_frac
      $error("kpa_product_align: FRAC_W must be at least 1");
   end
   if (LOG2_WORD < 1 || LOG2_WORD >= PEXP_W) begin : g_bad_word
      $error("kpa_product_align: LOG2_WORD out of range");
   end

   logic [EXP_W-1:0]  op_exp  [2];
   logic [FRAC_W-1:0] op_frac [2];
   logic [SIG_W-1:0]  op_sig  [2];
   logic [EXP_W-1:0]  op_eff  [2];
   logic [1:0]        op_zero;

   assign op_exp[0]  = a_exp;
   assign op_exp[1]  = b_exp;
   assign op_frac[0] = a_frac;
   assign op_frac[1] = b_frac;

   for (genvar i = 0; i < 2; i++) begin : g_unpack
      kpa_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) unpack_i (
         .exp_i     (op_exp[i]),
         .frac_i    (op_frac[i]),
         .sig_o     (op_sig[i]),
         .eff_exp_o (op_eff[i]),
         .zero_o    (op_zero[i])
      );
   end

   logic [MANT_W-1:0]  mant;
   logic [PEXP_W-1:0]  pexp;
   logic               neg;
   logic [ADDR_W-1:0]  addr_c;
   logic [FIELD_W-1:0] field_c;

   kpa_mul #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) mul_i (
      .sign_a_i (a_sign),
      .sign_b_i (b_sign),
      .sig_a_i  (op_sig[0]),
      .sig_b_i  (op_sig[1]),
      .eff_a_i  (op_eff[0]),
      .eff_b_i  (op_eff[1]),
      .zero_a_i (op_zero[0]),
      .zero_b_i (op_zero[1]),
      .mant_o   (mant),
      .pexp_o   (pexp),
      .neg_o    (neg)
   );

   kpa_align #(
      .MANT_W(MANT_W), .PEXP_W(PEXP_W), .LOG2_WORD(LOG2_WORD),
      .FIELD_W(FIELD_W), .NEG_INV(NEG_INV)
   ) align_i (
      .mant_i  (mant),
      .pexp_i  (pexp),
      .neg_i   (neg),
      .addr_o  (addr_c),
      .field_o (field_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sign  <= 1'b0;
         out_addr  <= '0;
         out_field <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_sign  <= neg;
            out_addr  <= addr_c;
            out_field <= field_c;
         end
      end
   end
endmodule

// File: rtl/kpa_product_align_chk.sv
module kpa_product_align_chk #(
   parameter int EXP_W   = 5,
   parameter int FRAC_W  = 10,
   parameter int ADDR_W  = 2,
   parameter int FIELD_W = 48,
   parameter int SPAN_W  = 37
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               a_sign,
   input logic [EXP_W-1:0]   a_exp,
   input logic [FRAC_W-1:0]  a_frac,
   input logic               b_sign,
   input logic [EXP_W-1:0]   b_exp,
   input logic [FRAC_W-1:0]  b_frac,
   input logic               out_valid,
   input logic               out_sign,
   input logic [ADDR_W-1:0]  out_addr,
   input logic [FIELD_W-1:0] out_field
);
   logic any_zero;
   assign any_zero = ((a_exp == '0) && (a_frac == '0)) || ((b_exp == '0) && (b_frac == '0));

   assert_sign_xor_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !any_zero) |=> (out_sign == $past(a_sign ^ b_sign)));

   assert_upper_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_sign) |-> ((out_field >> SPAN_W) == '0));

   assert_sign_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_sign == out_field[FIELD_W-1]));

   assert_zero_operand_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && any_zero) |=> ((out_field == '0) && !out_sign));

   assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_field) && $stable(out_sign) && $stable(out_addr)));

   assert_reset_clear_R8: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && (out_field == '0) && !out_sign && (out_addr == '0)));
endmodule

bind kpa_product_align kpa_product_align_chk #(
   .EXP_W(EXP_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W),
   .FIELD_W(FIELD_W), .SPAN_W(SPAN_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
   .a_sign(a_sign), .a_exp(a_exp), .a_frac(a_frac),
   .b_sign(b_sign), .b_exp(b_exp), .b_frac(b_frac),
   .out_valid(out_valid), .out_sign(out_sign),
   .out_addr(out_addr), .out_field(out_field)
);

// File: tb/kpa_product_align_tb_top.sv
module kpa_product_align_tb_top;
   localparam int EW = 5;
   localparam int FW = 10;
   localparam int LW = 4;
   localparam int AW = EW + 1 - LW;
   localparam int XW = 48;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          a_sign = 1'b0, b_sign = 1'b0;
   logic [EW-1:0] a_exp = '0, b_exp = '0;
   logic [FW-1:0] a_frac = '0, b_frac = '0;
   logic          out_valid, out_sign;
   logic [AW-1:0] out_addr;
   logic [XW-1:0] out_field;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   kpa_product_align dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .a_sign(a_sign), .a_exp(a_exp), .a_frac(a_frac),
      .b_sign(b_sign), .b_exp(b_exp), .b_frac(b_frac),
      .out_valid(out_valid), .out_sign(out_sign),
      .out_addr(out_addr), .out_field(out_field)
   );

   typedef struct packed {
      logic          sa;
      logic [EW-1:0] ea;
      logic [FW-1:0] fa;
      logic          sb;
      logic [EW-1:0] eb;
      logic [FW-1:0] fb;
      logic          xs;
      logic [AW-1:0] xa;
      logic [XW-1:0] xf;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      {1'b0, 5'd15, 10'h000, 1'b0, 5'd15, 10'h000, 1'b0, 2'd1, 48'h0001_0000_0000}, // R4 1.0*1.0
      {1'b1, 5'd15, 10'h000, 1'b0, 5'd15, 10'h000, 1'b1, 2'd1, 48'hFFFF_0000_0000}, // R5 negated
      {1'b0, 5'd31, 10'h3FF, 1'b0, 5'd31, 10'h3FF, 1'b0, 2'd3, 48'h0003_FF00_1000}, // R3 top address
      {1'b1, 5'd0,  10'h001, 1'b0, 5'd0,  10'h001, 1'b1, 2'd0, 48'hFFFF_FFFF_FFFF}, // R2 min subnormals
      {1'b0, 5'd0,  10'h001, 1'b0, 5'd15, 10'h000, 1'b0, 2'd0, 48'h0000_0100_0000}, // R2 subnormal*normal
      {1'b0, 5'd0,  10'h000, 1'b1, 5'd15, 10'h000, 1'b0, 2'd0, 48'h0000_0000_0000}, // R6 zero operand
      {1'b0, 5'd15, 10'h200, 1'b1, 5'd15, 10'h200, 1'b1, 2'd1, 48'hFFFD_C000_0000}, // R5 1.5*-1.5
      {1'b0, 5'd2,  10'h000, 1'b0, 5'd15, 10'h000, 1'b0, 2'd0, 48'h0008_0000_0000}  // R3 shift 15
   };

   task automatic check(input string tag, input logic [XW-1:0] got, input logic [XW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   // independent reference built from R1..R6
   task automatic ref_calc(input logic sa, input logic [EW-1:0] ea, input logic [FW-1:0] fa,
                           input logic sb, input logic [EW-1:0] eb, input logic [FW-1:0] fb,
                           output logic xs, output logic [AW-1:0] xa, output logic [XW-1:0] xf);
      longint unsigned ma, mb, ee, mt;
      ma = (ea == 0) ? longint'(fa) : (longint'(fa) + (64'd1 << FW));
      mb = (eb == 0) ? longint'(fb) : (longint'(fb) + (64'd1 << FW));
      ee = ((ea == 0) ? 1 : longint'(ea)) + ((eb == 0) ? 1 : longint'(eb)) - 2;
      mt = (ma * mb) << (ee % (1 << LW));
      xa = AW'(ee >> LW);
      xs = (sa ^ sb) && (ma != 0) && (mb != 0);
      xf = xs ? XW'((64'd1 << XW) - mt) : XW'(mt);
   endtask

   task automatic apply(input logic sa, input logic [EW-1:0] ea, input logic [FW-1:0] fa,
                        input logic sb, input logic [EW-1:0] eb, input logic [FW-1:0] fb);
      @(negedge clk);
      a_sign = sa; a_exp = ea; a_frac = fa;
      b_sign = sb; b_exp = eb; b_frac = fb;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
         $finish;
      end
   end

   initial begin
      logic xs;
      logic [AW-1:0] xa;
      logic [XW-1:0] xf;
      logic [XW-1:0] held;

      repeat (3) @(negedge clk);
      check("R8 out_valid in reset", XW'(out_valid), '0);
      check("R8 out_field in reset", out_field, '0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i].sa, VEC[i].ea, VEC[i].fa, VEC[i].sb, VEC[i].eb, VEC[i].fb);
         check($sformatf("R7 valid vec%0d", i), XW'(out_valid), XW'(1));
         check($sformatf("R1 sign vec%0d", i), XW'(out_sign), XW'(VEC[i].xs));
         check($sformatf("R3 addr vec%0d", i), XW'(out_addr), XW'(VEC[i].xa));
         check($sformatf("R4 R5 field vec%0d", i), out_field, VEC[i].xf);
      end

      for (int i = 0; i < 60; i++) begin
         logic sa, sb;
         logic [EW-1:0] ea, eb;
         logic [FW-1:0] fa, fb;
         sa = i[0]; sb = i[2];
         ea = EW'((i * 7) % 32);
         eb = EW'((i * 13 + 5) % 32);
         fa = (i % 9 == 0) ? '0 : FW'((i * 97 + 3) % 1024);
         fb = FW'((i * 331 + 17) % 1024);
         ref_calc(sa, ea, fa, sb, eb, fb, xs, xa, xf);
         apply(sa, ea, fa, sb, eb, fb);
         check($sformatf("R1 sweep sign %0d", i), XW'(out_sign), XW'(xs));
         check($sformatf("R3 sweep addr %0d", i), XW'(out_addr), XW'(xa));
         check($sformatf("R4 R5 R6 sweep field %0d", i), out_field, xf);
      end

      // hold while in_valid is low
      apply(1'b1, 5'd20, 10'h155, 1'b0, 5'd9, 10'h2AA);
      held = out_field;
      @(negedge clk);
      a_exp = 5'd3; b_exp = 5'd30; a_frac = 10'h3FF; a_sign = 1'b0;
      @(negedge clk);
      check("R7 out_valid low after idle", XW'(out_valid), '0);
      check("R7 field held", out_field, held);
      check("R7 sign held", XW'(out_sign), XW'(1));

      // zero times zero, both signs set
      apply(1'b1, 5'd0, 10'h000, 1'b0, 5'd0, 10'h000);
      check("R6 zero*zero field", out_field, '0);
      check("R6 zero*zero sign", XW'(out_sign), '0);

      // reset in mid run clears everything
      apply(1'b1, 5'd15, 10'h000, 1'b0, 5'd15, 10'h000);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R8 field cleared", out_field, '0);
      check("R8 sign cleared", XW'(out_sign), '0);
      check("R8 addr cleared", XW'(out_addr), '0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule